// File: doc/BRIEF.md
# Deferred-Exception Poison Tracker

This block keeps a one-bit poison flag for each of 128 general registers so that loads can be moved ahead of branches without risking a trap. When a speculative load faults, no exception is raised. The fault is recorded as poison on the load's destination register instead. ALU operations carry poison from their source registers to their destination. A later check operation on a register sends control to a fix-up address if that register is poisoned. Because poison spreads through every dependent operation, one check on the last register of a chain covers every speculative load that fed it.

Each cycle the block takes several decoded operation slots, or lanes. Each lane has a valid bit and a 3-bit kind code. Kind 1 is an ALU operation, kind 2 a normal load, kind 3 a speculative load and kind 4 a check. Kinds 0, 5, 6 and 7 do nothing. A lane also carries two source indices, a destination index, a fault flag and a fix-up target. The block outputs every poison flag and a registered redirect pulse with its target. Data values, memory access and the fix-up code itself are handled elsewhere.

Top module: `poison_tracker`

## Requirements
- R1: While reset is asserted, all poison flags read 0 and redir_valid is 0.
- R2: A valid speculative load (kind 3) with fault=1 sets the destination's flag. The new value is visible after the next rising clock edge.
- R3: A speculative load with fault=0 clears the destination's flag. A normal load (kind 2) clears the destination's flag whatever its fault flag is.
- R4: An ALU operation (kind 1) sets its destination flag to the OR of the flags of src_a and src_b.
- R5: A check (kind 4) whose src_a flag is set raises redir_valid for exactly one cycle, starting after the next rising edge, with redir_target equal to that lane's target. A check on a clean register raises no redirect and changes no flag.
- R6: Poison passed through a chain of ALU operations is caught by a single check on the chain's final register.
- R7: Register 0's flag always reads 0, and writes to it are discarded. As a source it is clean.
- R8: When two lanes in the same cycle write one register, the lane with the higher index decides its flag.
- R9: All lanes in a cycle read source flags as they stood at the start of that cycle. There is no forwarding between lanes.
- R10: A taken check cancels every higher-index lane in the same cycle, while lower-index lanes still take effect. Of several poisoned checks in one cycle, the lowest-index one supplies the target.
- R11: Lanes with valid=0, and lanes with kind 0, 5, 6 or 7, change no flag and cause no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | LANES | Per-lane valid |
| op_kind | input | 3*LANES | Per-lane kind code, lane i at bits [3i+2:3i] |
| op_src_a | input | 7*LANES | Per-lane first source index |
| op_src_b | input | 7*LANES | Per-lane second source index |
| op_dst | input | 7*LANES | Per-lane destination index |
| op_fault | input | LANES | Per-lane fault flag for loads |
| op_target | input | TW*LANES | Per-lane fix-up target for checks |
| poison_bits | output | 128 | Poison flag of every register, bit n for register n |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_target | output | TW | Fix-up target that goes with redir_valid |

## Verification
The bound properties check four things on every cycle: that register 0's flag is never set, that reset leaves every flag clear, that a cycle with no valid lane leaves all flags unchanged, and that a redirect pulse is only raised after a cycle that presented a check. The directed scenarios cover the rest. These are the values that loads and ALU operations write, the priority between lanes writing one register, the start-of-cycle view of sources, cancellation of later lanes after a taken check, and the correct fix-up target coming back for a poisoned chain.

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int NREGS = 128,
  parameter int LANES = 2,
  parameter int TW    = 16,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    op_valid,
  input  logic [3*LANES-1:0]  op_kind,
  input  logic [IW*LANES-1:0] op_src_a,
  input  logic [IW*LANES-1:0] op_src_b,
  input  logic [IW*LANES-1:0] op_dst,
  input  logic [LANES-1:0]    op_fault,
  input  logic [TW*LANES-1:0] op_target,
  output logic [NREGS-1:0]    poison_bits,
  output logic                redir_valid,
  output logic [TW-1:0]       redir_target
);

  localparam logic [2:0] K_ALU  = 3'd1;
  localparam logic [2:0] K_LD   = 3'd2;
  localparam logic [2:0] K_SLD  = 3'd3;
  localparam logic [2:0] K_CHK  = 3'd4;

  logic [NREGS-1:0] poison, nxt;
  logic             kill, hit;
  logic [TW-1:0]    tgt_n;
  logic [2:0]       kd;
  logic [IW-1:0]    ra, rb, rd;
  logic             wr, val;

  always_comb begin
    nxt   = poison;
    kill  = 1'b0;
    hit   = 1'b0;
    tgt_n = '0;
    kd = '0; ra = '0; rb = '0; rd = '0; wr = 1'b0; val = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      kd  = op_kind[3*i +: 3];
      ra  = op_src_a[IW*i +: IW];
      rb  = op_src_b[IW*i +: IW];
      rd  = op_dst[IW*i +: IW];
      wr  = 1'b0;
      val = 1'b0;
      if (op_valid[i] && !kill) begin
        case (kd)
          K_ALU: begin wr = 1'b1; val = poison[ra] | poison[rb]; end
          K_LD:  begin wr = 1'b1; val = 1'b0; end
          K_SLD: begin wr = 1'b1; val = op_fault[i]; end
          K_CHK: if (poison[ra]) begin
                   kill  = 1'b1;
                   hit   = 1'b1;
                   tgt_n = op_target[TW*i +: TW];
                 end
          default: ;
        endcase
      end
      if (wr && rd != '0) nxt[rd] = val;
    end
    nxt[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poison       <= '0;
      redir_valid  <= 1'b0;
      redir_target <= '0;
    end else begin
      poison       <= nxt;
      redir_valid  <= hit;
      redir_target <= tgt_n;
    end
  end

  assign poison_bits = poison;

endmodule

// File: rtl/poison_tracker_props.sv
module poison_tracker_props #(
  parameter int NREGS = 128,
  parameter int LANES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LANES-1:0]   op_valid,
  input logic [3*LANES-1:0] op_kind,
  input logic [NREGS-1:0]   poison_bits,
  input logic               redir_valid
);

  logic any_chk;
  always_comb begin
    any_chk = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (op_valid[i] && op_kind[3*i +: 3] == 3'd4) any_chk = 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (poison_bits == '0 && !redir_valid));

  p_reg0_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !poison_bits[0]);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid == '0) |=> $stable(poison_bits));

  p_redir_after_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(any_chk));

endmodule

bind poison_tracker poison_tracker_props #(.NREGS(NREGS), .LANES(LANES)) u_props (.*);

// File: tb/poison_tracker_test.sv
module poison_tracker_test;
  localparam int L = 2, TW = 16, IW = 7;

  logic clk = 0, rst_n = 0;
  logic [L-1:0] op_valid = '0, op_fault = '0;
  logic [3*L-1:0] op_kind = '0;
  logic [IW*L-1:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
  logic [TW*L-1:0] op_target = '0;
  logic [127:0] poison_bits;
  logic redir_valid;
  logic [TW-1:0] redir_target;
  int total = 0, failed = 0;

  poison_tracker uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lane(int i, logic [2:0] k, int a, int b, int d, logic f, logic [TW-1:0] t);
    op_valid[i] = 1'b1;
    op_kind[3*i +: 3] = k;
    op_src_a[IW*i +: IW] = IW'(a);
    op_src_b[IW*i +: IW] = IW'(b);
    op_dst[IW*i +: IW] = IW'(d);
    op_fault[i] = f;
    op_target[TW*i +: TW] = t;
  endtask

  task automatic step();
    @(posedge clk); #1;
    op_valid = '0; op_kind = '0; op_fault = '0;
    op_src_a = '0; op_src_b = '0; op_dst = '0; op_target = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 flags", 32'(poison_bits != '0), 0);
    chk("R1 redir", 32'(redir_valid), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_spec_fault();
    lane(0, 3, 0, 0, 5, 1, 0); step();
    chk("R2 set", 32'(poison_bits[5]), 1);
  endtask

  task automatic t_clear();
    lane(0, 3, 0, 0, 5, 0, 0); step();
    chk("R3 spec clean", 32'(poison_bits[5]), 0);
    lane(0, 3, 0, 0, 5, 1, 0); step();
    lane(0, 2, 0, 0, 5, 1, 0); step();
    chk("R3 normal load", 32'(poison_bits[5]), 0);
  endtask

  task automatic t_alu();
    lane(0, 3, 0, 0, 10, 1, 0); step();
    lane(0, 1, 11, 10, 12, 0, 0); step();
    chk("R4 or poisoned", 32'(poison_bits[12]), 1);
    lane(0, 1, 11, 13, 12, 0, 0); step();
    chk("R4 or clean", 32'(poison_bits[12]), 0);
  endtask

  task automatic t_check();
    lane(0, 4, 10, 0, 0, 0, 16'hBEEF); step();
    #0;
    chk("R5 redir", 32'(redir_valid), 1);
    chk("R5 target", 32'(redir_target), 32'hBEEF);
    @(negedge clk);
    chk("R5 one cycle", 32'(redir_valid), 0);
    lane(0, 4, 11, 0, 0, 0, 16'h1234); step();
    chk("R5 clean no redir", 32'(redir_valid), 0);
    chk("R5 no flag change", 32'(poison_bits[11] | !poison_bits[10]), 0);
  endtask

  task automatic t_chain();
    lane(0, 3, 0, 0, 20, 1, 0); step();
    lane(0, 1, 20, 21, 22, 0, 0); step();
    lane(0, 1, 0, 22, 23, 0, 0); step();
    lane(0, 4, 23, 0, 0, 0, 16'h0A0B); step();
    chk("R6 chain redir", 32'(redir_valid), 1);
    chk("R6 chain target", 32'(redir_target), 32'h0A0B);
  endtask

  task automatic t_zero();
    lane(0, 3, 0, 0, 0, 1, 0); step();
    chk("R7 reg0 write", 32'(poison_bits[0]), 0);
    lane(0, 1, 0, 0, 24, 0, 0); step();
    chk("R7 reg0 source", 32'(poison_bits[24]), 0);
  endtask

  task automatic t_order();
    lane(0, 3, 0, 0, 30, 1, 0); lane(1, 3, 0, 0, 30, 0, 0); step();
    chk("R8 later clean wins", 32'(poison_bits[30]), 0);
    lane(0, 3, 0, 0, 30, 0, 0); lane(1, 3, 0, 0, 30, 1, 0); step();
    chk("R8 later fault wins", 32'(poison_bits[30]), 1);
  endtask

  task automatic t_snapshot();
    lane(0, 3, 0, 0, 40, 1, 0); lane(1, 1, 40, 0, 41, 0, 0); step();
    chk("R9 writer set", 32'(poison_bits[40]), 1);
    chk("R9 no forward", 32'(poison_bits[41]), 0);
  endtask

  task automatic t_squash();
    lane(0, 3, 0, 0, 50, 1, 0); step();
    lane(0, 4, 50, 0, 0, 0, 16'h1111); lane(1, 3, 0, 0, 51, 1, 0); step();
    chk("R10 later cancelled", 32'(poison_bits[51]), 0);
    chk("R10 target", 32'(redir_target), 32'h1111);
    lane(0, 4, 0, 0, 0, 0, 16'h2222); lane(1, 4, 50, 0, 0, 0, 16'h3333); step();
    chk("R10 second lane check", 32'(redir_target), 32'h3333);
    lane(0, 4, 50, 0, 0, 0, 16'h4444); lane(1, 4, 50, 0, 0, 0, 16'h5555); step();
    chk("R10 lowest lane wins", 32'(redir_target), 32'h4444);
    lane(0, 3, 0, 0, 52, 1, 0); lane(1, 4, 50, 0, 0, 0, 16'h6666); step();
    chk("R10 earlier applies", 32'(poison_bits[52]), 1);
  endtask

  task automatic t_ignored();
    lane(0, 3, 0, 0, 60, 1, 0); op_valid[0] = 1'b0; step();
    chk("R11 invalid lane", 32'(poison_bits[60]), 0);
    lane(0, 6, 0, 0, 60, 1, 0); step();
    chk("R11 kind 6", 32'(poison_bits[60]), 0);
    lane(0, 3, 0, 0, 61, 1, 0); step();
    lane(0, 0, 0, 0, 61, 0, 0); lane(1, 5, 61, 0, 61, 0, 16'h7777); step();
    chk("R11 kind 0/5 keep", 32'(poison_bits[61]), 1);
    chk("R11 no redir", 32'(redir_valid), 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_spec_fault(); t_clear(); t_alu(); t_check();
        t_chain(); t_zero(); t_order(); t_snapshot(); t_squash(); t_ignored();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule